// File: doc/BRIEF.md
# Warp Hit-Ratio Classifier

This block watches the stream of cache lookups made by the warps of one GPU core and, for every warp, counts how many lookups it issued and how many of them hit. At the close of each epoch it turns those two counts into one of five hit-ratio bands and latches the band into a per-warp class register. Bypass, insertion and request-scheduling logic read a warp's band through a combinational lookup port and can then treat warps that mostly hit differently from warps that mostly miss.

Each lookup arrives on a valid/ready channel carrying the warp number and a hit flag. The ratio is never divided out. The block compares the scaled hit count against the scaled access count with constant thresholds. An epoch pulse closes the measurement window. It updates the bands of every warp that saw enough traffic and then clears all counters. The channel stalls for the one cycle in which the pulse is high, so that no lookup falls between the update and the clear.

Top module: `whr_classifier`

## Requirements
- R1: Bands are encoded in priority order, highest first: 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss, 4 all-miss. `query_class` shows the latched band of warp `query_warp` in the same cycle, and it is never above 4.
- R2: After reset every warp reads balanced (2) until the first epoch pulse updates it.
- R3: At an epoch pulse, a warp with at least MIN_ACC (default 4) lookups gets all-hit when every lookup hit, and all-miss when none hit.
- R4: When some but not all lookups hit, the band is mostly-hit if 10·hits ≥ 7·lookups, balanced if 10·hits ≥ 2·lookups (and below the mostly-hit bound), and mostly-miss otherwise. The exact ratios 0.7 and 0.2 fall into the higher band.
- R5: A band changes only at the clock edge that ends a cycle with `epoch_tick` high. It holds its value at every other edge.
- R6: At an epoch pulse, a warp with fewer than MIN_ACC lookups keeps its previous band. After the pulse, all counters of all warps restart from zero.
- R7: Counters saturate and do not wrap. Once a warp's lookup count reaches 2^CNT_W−1 (255 by default), further lookups change neither of its counts.
- R8: `acc_ready` is low in every cycle in which `epoch_tick` is high and high in all other cycles. A lookup is taken only at an edge where `acc_valid` and `acc_ready` are both high, and it counts toward the next epoch pulse. A lookup offered during the pulse must be held by the sender and is not counted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache lookup is offered |
| acc_ready | output | 1 | Block takes the offered lookup this cycle |
| acc_warp | input | WID_W (4) | Warp number of the lookup |
| acc_hit | input | 1 | 1 = lookup hit, 0 = missed |
| epoch_tick | input | 1 | One-cycle pulse closing the measurement window |
| query_warp | input | WID_W (4) | Warp whose band is read |
| query_class | output | 3 | Latched band of `query_warp` |

## Verification
The hardest state to reach from the ports is counter saturation. A single warp needs 255 taken lookups inside one epoch, and a later wrong-way run of lookups must then leave its band unchanged. The bench drives that run as a directed sequence. Exact-threshold ratios (7 of 10 and 2 of 10) and a lookup offered in the same cycle as the epoch pulse are also forced directly. Per-epoch random hit biases cover the other bands across all warps.

// File: rtl/whr_pkg.sv
package whr_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALL_HIT     = 3'd0,
    CLS_MOSTLY_HIT  = 3'd1,
    CLS_BALANCED    = 3'd2,
    CLS_MOSTLY_MISS = 3'd3,
    CLS_ALL_MISS    = 3'd4
  } whr_class_e;
endpackage

// File: rtl/whr_counter_bank.sv
module whr_counter_bank #(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 8,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              inc_en,
  input  logic [WID_W-1:0]                  inc_warp,
  input  logic                              inc_hit,
  input  logic                              clear,
  output logic [NUM_WARPS-1:0][CNT_W-1:0]   hit_vec,
  output logic [NUM_WARPS-1:0][CNT_W-1:0]   acc_vec
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic sel;
    assign sel = inc_en && (inc_warp == WID_W'(g)) && (acc_vec[g] != CNT_MAX);

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        acc_vec[g] <= '0;
        hit_vec[g] <= '0;
      end else if (sel) begin
        acc_vec[g] <= acc_vec[g] + 1'b1;
        if (inc_hit) hit_vec[g] <= hit_vec[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/whr_band_eval.sv
module whr_band_eval
  import whr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DEN     = 10,
  parameter int HI_NUM  = 7,
  parameter int LO_NUM  = 2,
  parameter int MIN_ACC = 4
) (
  input  logic [CNT_W-1:0] hits,
  input  logic [CNT_W-1:0] accs,
  output logic [CLS_W-1:0] band,
  output logic             enough
);
  localparam int PW = CNT_W + 8;

  logic [PW-1:0] hit_scaled, hi_bound, lo_bound;

  always_comb begin
    hit_scaled = PW'(hits) * PW'(DEN);
    hi_bound   = PW'(accs) * PW'(HI_NUM);
    lo_bound   = PW'(accs) * PW'(LO_NUM);
    enough     = (PW'(accs) >= PW'(MIN_ACC));
    if (hits == accs)              band = CLS_ALL_HIT;
    else if (hits == '0)           band = CLS_ALL_MISS;
    else if (hit_scaled >= hi_bound) band = CLS_MOSTLY_HIT;
    else if (hit_scaled >= lo_bound) band = CLS_BALANCED;
    else                           band = CLS_MOSTLY_MISS;
  end
endmodule

// File: rtl/whr_class_file.sv
module whr_class_file
  import whr_pkg::*;
#(
  parameter int NUM_WARPS = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               update,
  input  logic [NUM_WARPS-1:0]               upd_mask,
  input  logic [NUM_WARPS-1:0][CLS_W-1:0]    new_cls,
  output logic [NUM_WARPS-1:0][CLS_W-1:0]    cls_vec
);
  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         cls_vec[g] <= CLS_BALANCED;
      else if (update && upd_mask[g])     cls_vec[g] <= new_cls[g];
    end
  end
endmodule

// File: rtl/whr_classifier.sv
module whr_classifier
  import whr_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 8,
  parameter int MIN_ACC   = 4,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [WID_W-1:0] acc_warp,
  input  logic             acc_hit,
  input  logic             epoch_tick,
  input  logic [WID_W-1:0] query_warp,
  output logic [CLS_W-1:0] query_class
);
  logic [NUM_WARPS-1:0][CNT_W-1:0] hit_vec, acc_vec;
  logic [NUM_WARPS-1:0][CLS_W-1:0] band_vec, cls_vec;
  logic [NUM_WARPS-1:0]            enough_vec;

  assign acc_ready = !epoch_tick;

  whr_counter_bank #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (acc_valid && acc_ready),
    .inc_warp (acc_warp),
    .inc_hit  (acc_hit),
    .clear    (epoch_tick),
    .hit_vec  (hit_vec),
    .acc_vec  (acc_vec)
  );

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_eval
    whr_band_eval #(.CNT_W(CNT_W), .MIN_ACC(MIN_ACC)) eval_i (
      .hits   (hit_vec[g]),
      .accs   (acc_vec[g]),
      .band   (band_vec[g]),
      .enough (enough_vec[g])
    );
  end

  whr_class_file #(.NUM_WARPS(NUM_WARPS)) cls_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .update   (epoch_tick),
    .upd_mask (enough_vec),
    .new_cls  (band_vec),
    .cls_vec  (cls_vec)
  );

  assign query_class = cls_vec[query_warp];
endmodule

// File: rtl/whr_classifier_chk.sv
module whr_classifier_chk
  import whr_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             epoch_tick,
  input logic [NUM_WARPS-1:0][CLS_W-1:0]  cls_vec,
  input logic [NUM_WARPS-1:0][CNT_W-1:0]  hit_vec,
  input logic [NUM_WARPS-1:0][CNT_W-1:0]  acc_vec,
  input logic [CLS_W-1:0]                 query_class
);
  logic seen_tick;
  logic all_bal;

  always_ff @(posedge clk) begin
    if (!rst_n)          seen_tick <= 1'b0;
    else if (epoch_tick) seen_tick <= 1'b1;
  end

  always_comb begin
    all_bal = 1'b1;
    for (int i = 0; i < NUM_WARPS; i++)
      if (cls_vec[i] != CLS_BALANCED) all_bal = 1'b0;
  end

  p_legal_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    query_class <= CLS_ALL_MISS);

  p_reset_balanced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_tick |-> all_bal);

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_tick |=> $stable(cls_vec));

  p_clear_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_tick |=> (acc_vec == '0 && hit_vec == '0));

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_sat
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] <= acc_vec[g]);
  end
endmodule

bind whr_classifier whr_classifier_chk #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .epoch_tick  (epoch_tick),
  .cls_vec     (cls_vec),
  .hit_vec     (hit_vec),
  .acc_vec     (acc_vec),
  .query_class (query_class)
);

// File: tb/whr_classifier_tb.sv
module whr_classifier_tb_top;
  localparam int NW   = 16;
  localparam int CMAX = 255;
  localparam int MINA = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic [3:0] acc_warp = '0;
  logic       acc_hit = 1'b0;
  logic       epoch_tick = 1'b0;
  logic [3:0] query_warp = '0;
  logic [2:0] query_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_hit [NW];
  int m_acc [NW];
  int m_cls [NW];

  always #2 clk = ~clk;

  whr_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_warp(acc_warp), .acc_hit(acc_hit), .epoch_tick(epoch_tick),
    .query_warp(query_warp), .query_class(query_class)
  );

  function automatic int band_of(int h, int a);
    if (h == a)             return 0;
    if (h == 0)             return 4;
    if (h * 10 >= a * 7)    return 1;
    if (h * 10 >= a * 2)    return 2;
    return 3;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(int w, bit h);
    @(negedge clk);
    acc_valid = 1'b1; acc_warp = 4'(w); acc_hit = h;
    @(posedge clk);
    #1 acc_valid = 1'b0;
    if (m_acc[w] < CMAX) begin
      m_acc[w]++;
      if (h) m_hit[w]++;
    end
  endtask

  task automatic tick(bit stray, int sw);
    @(negedge clk);
    epoch_tick = 1'b1;
    acc_valid = stray; acc_warp = 4'(sw); acc_hit = 1'b0;
    #1 check("R8 ready low on tick", int'(acc_ready), 0);
    @(posedge clk);
    #1 epoch_tick = 1'b0; acc_valid = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (m_acc[w] >= MINA) m_cls[w] = band_of(m_hit[w], m_acc[w]);
      m_acc[w] = 0; m_hit[w] = 0;
    end
  endtask

  task automatic check_all(string req);
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      query_warp = 4'(w);
      #1 check(req, int'(query_class), m_cls[w]);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int w = 0; w < NW; w++) begin m_hit[w] = 0; m_acc[w] = 0; m_cls[w] = 2; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R2 reset balanced");
    @(negedge clk);
    check("R8 ready high idle", int'(acc_ready), 1);
    // accesses without a tick must not move any class (R5)
    for (int i = 0; i < 8; i++) access(0, 1'b1);
    check_all("R5 held before tick");

    // directed bands: R3 and R4 incl. exact thresholds
    for (int i = 0; i < 10; i++) access(1, i < 7);   // 0.7 -> mostly-hit
    for (int i = 0; i < 10; i++) access(2, i < 2);   // 0.2 -> balanced
    for (int i = 0; i < 10; i++) access(3, i < 1);   // 0.1 -> mostly-miss
    for (int i = 0; i < 10; i++) access(4, i < 6);   // 0.6 -> balanced
    for (int i = 0; i < 5; i++)  access(5, 1'b0);    // all-miss
    for (int i = 0; i < 3; i++)  access(6, 1'b0);    // too few: keep (R6)
    tick(1'b1, 7);                                   // stray on warp 7 not counted (R8)
    check_all("R3 R4 R6 directed bands");
    check("R4 exact 0.7 mostly-hit", m_cls[1], 1);
    check("R4 exact 0.2 balanced", m_cls[2], 2);

    // counters cleared after tick (R6): fresh all-miss on warp 0
    for (int i = 0; i < 4; i++) access(0, 1'b0);
    for (int i = 0; i < 3; i++) access(7, 1'b1);     // 3 + stray would reach MIN
    tick(1'b0, 0);
    check_all("R6 clear and R8 stray");
    tick(1'b0, 0);
    check_all("R6 empty epoch keeps class");

    // saturation (R7)
    for (int i = 0; i < CMAX; i++) access(8, 1'b1);
    for (int i = 0; i < 12; i++) access(8, 1'b0);
    tick(1'b0, 0);
    check_all("R7 saturation");
    check("R7 saturated warp all-hit", m_cls[8], 0);

    // random epochs
    for (int e = 0; e < 8; e++) begin
      int bias [NW];
      for (int w = 0; w < NW; w++) begin
        case ($urandom_range(0, 4))
          0: bias[w] = 100;
          1: bias[w] = 0;
          default: bias[w] = $urandom_range(1, 99);
        endcase
      end
      for (int i = 0; i < 300; i++) begin
        int w = (i % 5 == 0) ? $urandom_range(0, NW - 1) : $urandom_range(0, NW / 2 - 1);
        access(w, $urandom_range(0, 99) < bias[w]);
      end
      tick($urandom_range(0, 1) == 1, $urandom_range(0, NW - 1));
      check_all("R1 R4 random epoch");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule